// File: doc/BRIEF.md
# Speculative Consumer Stall Controller

This block holds speculative consumer threads that attempted to read a line marked for stall-based handling, and decides when each may resume. Every held thread occupies one of a small, fixed set of entries that record its thread ID, its numeric order position, the line tag and the chosen policy. If no entry is free, the request is refused with a retry indication and nothing is recorded.

Two policies exist. Under the commit-release policy, a held thread is freed when a thread with a lower position commits a modified copy of the same line, provided no thread ordered strictly between the two holds its own modified copy. The directory presents that information as one bit per position alongside the commit. Once freed, the thread stays watched: a later write violation on the line by a predecessor makes the block ask for its squash. The watch ends when the thread reaches the head position. Under the head-wait policy, a commit is not enough, and the thread is freed only once its position equals the current head (non-speculative) position. The block only issues release and squash requests; the directory and the squash machinery act on them.

Top module: `stall_ctrl`

## Requirements
- R1: After reset, `rel_valid` and `sq_valid` are 0 and every entry is free, so a request gets `req_retry` = 0.
- R2: `req_retry` is high in the same cycle as a request exactly when all NENT entries are occupied; a refused request is dropped and never released.
- R3: With `req_wait` = 0, a commit with matching tag and `cm_pos` strictly below the consumer's position, and with no bit of `cm_mod` set strictly between the two positions, gives `rel_valid` = 1 with the consumer's ID two clock edges after the commit is sampled.
- R4: A set bit of `cm_mod` (bit i for position i) strictly between producer and consumer blocks that release; bits at the producer's position, at the consumer's position, or beyond the consumer do not.
- R5: A commit with a different tag, or with `cm_pos` greater than or equal to the consumer's position, releases nothing.
- R6: With `req_wait` = 1, commits release nothing; the thread is released two clock edges after `head_pos` is sampled equal to its position.
- R7: At most one release is issued per cycle; when several threads are eligible, they are released on successive cycles by increasing position.
- R8: A released commit-release thread gets `sq_valid` = 1 with its ID two edges after a violation with matching tag and `viol_pos` strictly below its position is sampled; a violation with another tag or from a position at or above it does nothing.
- R9: A released thread whose position is sampled equal to `head_pos` stops being watched and its entry is freed; later violations on its line cause no squash.
- R10: A violation on a thread that is still held causes no squash and leaves it held, so a later qualifying commit still releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A consumer read hit a stall-flagged line |
| req_tid | input | TIDW | Consumer thread ID |
| req_pos | input | PW | Consumer order position (lower is older) |
| req_tag | input | TAGW | Line tag |
| req_wait | input | 1 | 1 = head-wait policy, 0 = commit-release policy |
| req_retry | output | 1 | No free entry; request not taken |
| cm_valid | input | 1 | A thread commits a modified line |
| cm_pos | input | PW | Position of committing thread |
| cm_tag | input | TAGW | Tag of committed line |
| cm_mod | input | 2**PW | Bit i set: thread at position i holds a modified copy |
| viol_valid | input | 1 | Write violation reported |
| viol_pos | input | PW | Position of the writing thread |
| viol_tag | input | TAGW | Tag of the written line |
| head_pos | input | PW | Position of the non-speculative thread |
| rel_valid | output | 1 | Release request this cycle |
| rel_tid | output | TIDW | Thread to release |
| sq_valid | output | 1 | Squash request this cycle |
| sq_tid | output | TIDW | Thread to squash |

## Verification
The commit-release decision is driven from a table of single-consumer cases that vary the producer position against the consumer, the tag match and where the modified-copy bit sits (between, at either end, beyond), which separates an off-by-one in the strict ordering bounds from a missing tag compare. Three threads made eligible by one commit tell oldest-first ordering apart from entry-index ordering, since they are allocated out of position order. Violations are applied before release, after release and after the thread reaches the head, which distinguishes a correct watch window from one that opens too early or never closes.

// File: rtl/stall_ctrl_pkg.sv
package stall_ctrl_pkg;
    // Per-entry lifecycle
    localparam logic [2:0] E_FREE   = 3'd0;
    localparam logic [2:0] E_HELD   = 3'd1;
    localparam logic [2:0] E_READY  = 3'd2;
    localparam logic [2:0] E_WATCH  = 3'd3;
    localparam logic [2:0] E_SQPEND = 3'd4;
endpackage

// File: rtl/stall_free_pick.sv
module stall_free_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  free_vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/stall_oldest_pick.sv
module stall_oldest_pick #(
    parameter int N  = 4,
    parameter int PW = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][PW-1:0] pos,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    logic [PW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || pos[i] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = pos[i];
            end
        end
    end
endmodule

// File: rtl/stall_order_gate.sv
module stall_order_gate #(
    parameter int PW   = 4,
    localparam int NPOS = 1 << PW
) (
    input  logic [PW-1:0]   cons_pos,
    input  logic [PW-1:0]   prod_pos,
    input  logic [NPOS-1:0] mod_mask,
    output logic            ok
);
    logic blocked;

    always_comb begin
        blocked = 1'b0;
        for (int i = 0; i < NPOS; i++) begin
            if (mod_mask[i] && (i > int'(prod_pos)) && (i < int'(cons_pos)))
                blocked = 1'b1;
        end
        ok = (prod_pos < cons_pos) && !blocked;
    end
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
    import stall_ctrl_pkg::*;
#(
    parameter int NENT = 4,
    parameter int TIDW = 6,
    parameter int PW   = 4,
    parameter int TAGW = 12,
    localparam int NPOS = 1 << PW,
    localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [TIDW-1:0] req_tid,
    input  logic [PW-1:0]   req_pos,
    input  logic [TAGW-1:0] req_tag,
    input  logic            req_wait,
    output logic            req_retry,
    input  logic            cm_valid,
    input  logic [PW-1:0]   cm_pos,
    input  logic [TAGW-1:0] cm_tag,
    input  logic [NPOS-1:0] cm_mod,
    input  logic            viol_valid,
    input  logic [PW-1:0]   viol_pos,
    input  logic [TAGW-1:0] viol_tag,
    input  logic [PW-1:0]   head_pos,
    output logic            rel_valid,
    output logic [TIDW-1:0] rel_tid,
    output logic            sq_valid,
    output logic [TIDW-1:0] sq_tid
);
    typedef struct packed {
        logic [NENT-1:0][2:0]      st;
        logic [NENT-1:0]           wmode;
        logic [NENT-1:0][TIDW-1:0] tid;
        logic [NENT-1:0][PW-1:0]   pos;
        logic [NENT-1:0][TAGW-1:0] tag;
        logic                      rel_v;
        logic [TIDW-1:0]           rel_t;
        logic                      sq_v;
        logic [TIDW-1:0]           sq_t;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [NENT-1:0] free_vec, ready_vec, sqp_vec, order_ok;
    logic            free_found, rel_found, sq_found;
    logic [IW-1:0]   free_idx, rel_idx, sq_idx;

    // Per-entry producer/consumer ordering check for the current commit
    for (genvar g = 0; g < NENT; g++) begin : g_gate
        stall_order_gate #(.PW(PW)) u_gate (
            .cons_pos (s_q.pos[g]),
            .prod_pos (cm_pos),
            .mod_mask (cm_mod),
            .ok       (order_ok[g])
        );
        assign free_vec[g]  = (s_q.st[g] == E_FREE);
        assign ready_vec[g] = (s_q.st[g] == E_READY);
        assign sqp_vec[g]   = (s_q.st[g] == E_SQPEND);
    end

    stall_free_pick #(.N(NENT)) u_free (
        .free_vec (free_vec),
        .found    (free_found),
        .idx      (free_idx)
    );

    stall_oldest_pick #(.N(NENT), .PW(PW)) u_rel_pick (
        .cand  (ready_vec),
        .pos   (s_q.pos),
        .found (rel_found),
        .idx   (rel_idx)
    );

    stall_oldest_pick #(.N(NENT), .PW(PW)) u_sq_pick (
        .cand  (sqp_vec),
        .pos   (s_q.pos),
        .found (sq_found),
        .idx   (sq_idx)
    );

    assign req_retry = req_valid && !free_found;

    always_comb begin
        s_d = s_q;

        // Entry state transitions driven by commits, head and violations
        for (int i = 0; i < NENT; i++) begin
            case (s_q.st[i])
                E_HELD: begin
                    if (s_q.pos[i] == head_pos)
                        s_d.st[i] = E_READY;
                    else if (!s_q.wmode[i] && cm_valid &&
                             (cm_tag == s_q.tag[i]) && order_ok[i])
                        s_d.st[i] = E_READY;
                end
                E_WATCH: begin
                    if (s_q.pos[i] == head_pos)
                        s_d.st[i] = E_FREE;
                    else if (viol_valid && (viol_tag == s_q.tag[i]) &&
                             (viol_pos < s_q.pos[i]))
                        s_d.st[i] = E_SQPEND;
                end
                default: ;
            endcase
        end

        // One release per cycle, oldest position first
        s_d.rel_v = rel_found;
        s_d.rel_t = rel_found ? s_q.tid[rel_idx] : '0;
        if (rel_found)
            s_d.st[rel_idx] = s_q.wmode[rel_idx] ? E_FREE : E_WATCH;

        // One squash per cycle, oldest position first
        s_d.sq_v = sq_found;
        s_d.sq_t = sq_found ? s_q.tid[sq_idx] : '0;
        if (sq_found)
            s_d.st[sq_idx] = E_FREE;

        // Allocation of a new held thread
        if (req_valid && free_found) begin
            s_d.st[free_idx]    = E_HELD;
            s_d.wmode[free_idx] = req_wait;
            s_d.tid[free_idx]   = req_tid;
            s_d.pos[free_idx]   = req_pos;
            s_d.tag[free_idx]   = req_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rel_valid = s_q.rel_v;
    assign rel_tid   = s_q.rel_t;
    assign sq_valid  = s_q.sq_v;
    assign sq_tid    = s_q.sq_t;
endmodule

// File: rtl/stall_ctrl_chk.sv
module stall_ctrl_chk #(
    parameter int TIDW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_retry,
    input logic            rel_valid,
    input logic [TIDW-1:0] rel_tid,
    input logic            sq_valid,
    input logic [TIDW-1:0] sq_tid
);
    // R2
    retry_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_retry |-> req_valid);

    // R7
    rel_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && $past(rel_valid)) |-> (rel_tid != $past(rel_tid)));

    // R8
    sq_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && $past(sq_valid)) |-> (sq_tid != $past(sq_tid)));

    // R8
    rel_sq_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && sq_valid) |-> (rel_tid != sq_tid));
endmodule

bind stall_ctrl stall_ctrl_chk #(.TIDW(TIDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_retry (req_retry),
    .rel_valid (rel_valid),
    .rel_tid   (rel_tid),
    .sq_valid  (sq_valid),
    .sq_tid    (sq_tid)
);

// File: tb/stall_ctrl_tb.sv
module stall_ctrl_tb;
    localparam int NENT = 4, TIDW = 6, PW = 4, TAGW = 12, NPOS = 16;
    localparam logic [TAGW-1:0] TAG_A = 12'h3A5, TAG_B = 12'h0C1;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_wait = 0, cm_valid = 0, viol_valid = 0;
    logic [TIDW-1:0] req_tid = 0;
    logic [PW-1:0] req_pos = 0, cm_pos = 0, viol_pos = 0, head_pos = 0;
    logic [TAGW-1:0] req_tag = 0, cm_tag = 0, viol_tag = 0;
    logic [NPOS-1:0] cm_mod = 0;
    logic req_retry, rel_valid, sq_valid;
    logic [TIDW-1:0] rel_tid, sq_tid;

    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tid(req_tid), .req_pos(req_pos),
        .req_tag(req_tag), .req_wait(req_wait), .req_retry(req_retry),
        .cm_valid(cm_valid), .cm_pos(cm_pos), .cm_tag(cm_tag), .cm_mod(cm_mod),
        .viol_valid(viol_valid), .viol_pos(viol_pos), .viol_tag(viol_tag),
        .head_pos(head_pos),
        .rel_valid(rel_valid), .rel_tid(rel_tid),
        .sq_valid(sq_valid), .sq_tid(sq_tid)
    );

    typedef struct packed {
        logic            wmode;
        logic [PW-1:0]   cpos;
        logic [PW-1:0]   ppos;
        logic [NPOS-1:0] mask;
        logic            same_tag;
        logic            exp_rel;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'd5, 4'd2, 16'h0000, 1'b1, 1'b1},  // R3 plain release
        '{1'b0, 4'd5, 4'd2, 16'h0008, 1'b1, 1'b0},  // R4 blocker between
        '{1'b0, 4'd5, 4'd2, 16'h0004, 1'b1, 1'b1},  // R4 bit at producer
        '{1'b0, 4'd5, 4'd2, 16'h0020, 1'b1, 1'b1},  // R4 bit at consumer
        '{1'b0, 4'd5, 4'd5, 16'h0000, 1'b1, 1'b0},  // R5 equal position
        '{1'b0, 4'd5, 4'd7, 16'h0000, 1'b1, 1'b0},  // R5 successor commit
        '{1'b0, 4'd5, 4'd2, 16'h0000, 1'b0, 1'b0},  // R5 other tag
        '{1'b1, 4'd5, 4'd2, 16'h0000, 1'b1, 1'b0},  // R6 commit ignored
        '{1'b0, 4'd9, 4'd1, 16'h0400, 1'b1, 1'b1}   // R4 bit beyond consumer
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R3";
            4, 5, 6: return "R5";
            7: return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; req_valid = 0; cm_valid = 0; viol_valid = 0; head_pos = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic request(logic [TIDW-1:0] t, logic [PW-1:0] p,
                           logic [TAGW-1:0] g, logic w);
        req_valid = 1; req_tid = t; req_pos = p; req_tag = g; req_wait = w;
        tick();
        req_valid = 0;
    endtask

    task automatic commit(logic [PW-1:0] p, logic [TAGW-1:0] g, logic [NPOS-1:0] m);
        cm_valid = 1; cm_pos = p; cm_tag = g; cm_mod = m;
        tick();
        cm_valid = 0; cm_mod = 0;
    endtask

    task automatic violate(logic [PW-1:0] p, logic [TAGW-1:0] g);
        viol_valid = 1; viol_pos = p; viol_tag = g;
        tick();
        viol_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 rel_valid", 32'(rel_valid), 0);
        chk("R1 sq_valid", 32'(sq_valid), 0);
        req_valid = 1; #1;
        chk("R1 retry", 32'(req_retry), 0);
        req_valid = 0;

        // Table of single-consumer commit cases (R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            do_reset();
            request(TIDW'(20 + i), VEC[i].cpos, TAG_A, VEC[i].wmode);
            commit(VEC[i].ppos, VEC[i].same_tag ? TAG_A : TAG_B, VEC[i].mask);
            tick();
            chk(vec_req(i), 32'(rel_valid), 32'(VEC[i].exp_rel));
            if (VEC[i].exp_rel)
                chk(vec_req(i), 32'(rel_tid), 32'(20 + i));
        end

        // R6 head-wait thread released at head
        do_reset();
        request(6'd30, 4'd6, TAG_A, 1'b1);
        commit(4'd2, TAG_A, '0);
        tick();
        chk("R6 no release on commit", 32'(rel_valid), 0);
        head_pos = 4'd6;
        tick(); tick();
        chk("R6 release at head", 32'(rel_valid), 1);
        chk("R6 tid", 32'(rel_tid), 30);
        head_pos = 0;

        // R7 oldest first, one per cycle
        do_reset();
        request(6'd13, 4'd7, TAG_A, 1'b0);
        request(6'd11, 4'd3, TAG_A, 1'b0);
        request(6'd12, 4'd5, TAG_A, 1'b0);
        commit(4'd1, TAG_A, '0);
        tick();
        chk("R7 first", {26'd0, rel_valid, rel_tid}, {26'd0, 1'b1, 6'd11});
        tick();
        chk("R7 second", {26'd0, rel_valid, rel_tid}, {26'd0, 1'b1, 6'd12});
        tick();
        chk("R7 third", {26'd0, rel_valid, rel_tid}, {26'd0, 1'b1, 6'd13});
        tick();
        chk("R7 done", 32'(rel_valid), 0);

        // R8 squash of a released thread
        do_reset();
        request(6'd7, 4'd5, TAG_A, 1'b0);
        commit(4'd2, TAG_A, '0);
        tick();
        chk("R8 released", 32'(rel_valid), 1);
        violate(4'd2, TAG_B);
        tick();
        chk("R8 other tag", 32'(sq_valid), 0);
        violate(4'd6, TAG_A);
        tick();
        chk("R8 later writer", 32'(sq_valid), 0);
        violate(4'd3, TAG_A);
        tick();
        chk("R8 squash", {26'd0, sq_valid, sq_tid}, {26'd0, 1'b1, 6'd7});
        tick();
        chk("R8 single squash", 32'(sq_valid), 0);

        // R10 violation while held
        do_reset();
        request(6'd9, 4'd5, TAG_A, 1'b0);
        violate(4'd2, TAG_A);
        tick();
        chk("R10 no squash", 32'(sq_valid), 0);
        commit(4'd2, TAG_A, '0);
        tick();
        chk("R10 still held", {26'd0, rel_valid, rel_tid}, {26'd0, 1'b1, 6'd9});

        // R9 watch ends at head
        do_reset();
        request(6'd3, 4'd4, TAG_A, 1'b0);
        commit(4'd1, TAG_A, '0);
        tick();
        chk("R9 released", 32'(rel_valid), 1);
        head_pos = 4'd4;
        tick();
        head_pos = 0;
        violate(4'd1, TAG_A);
        tick();
        chk("R9 no squash", 32'(sq_valid), 0);

        // R2 full table
        do_reset();
        for (int k = 1; k <= NENT; k++) begin
            req_valid = 1; req_tid = TIDW'(k); req_pos = PW'(k); req_tag = TAG_A;
            req_wait = 0; #1;
            chk("R2 accept", 32'(req_retry), 0);
            tick();
        end
        req_tid = 6'd40; req_pos = 4'd9; req_wait = 1; #1;
        chk("R2 retry when full", 32'(req_retry), 1);
        tick();
        req_valid = 0;
        head_pos = 4'd9;
        tick(); tick();
        chk("R2 dropped request", 32'(rel_valid), 0);
        head_pos = 0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule